// File: doc/BRIEF.md
# Row Exposure Sequencer with Grouped Precharge

This block drives one display row at a time on a passive-matrix emissive panel. For every column it turns a latched 6-bit exposure value into a drive state. The state is ground (off), precharge (the diode is brought up to its threshold), or current source (on). A single-cycle row-start pulse loads every column counter with its exposure value. The same pulse loads three colour-group precharge timers and opens the row.

Columns are split into three colour groups by column index modulo 3. Each group has its own precharge duration, counted in exposure-clock ticks. A column holds the precharge state while its group's timer runs. After that it sources current for exactly as many exposure ticks as its exposure value, then returns to ground for the rest of the row.

Two handshake outputs serve an external row driver:
- a one-cycle row-clock pulse at the start of each row;
- a level that goes high once all three groups have finished precharging.

Top module: `row_exposure_sequencer`

## Requirements
- R1: While `rst` is high, and after it until the first `row_start`, every column reads ground (code 2'b00), and `row_clk` and `row_pre_done` are low. Exposure ticks in that interval change nothing.
- R2: Each column's 2-bit state field at bits [2c+1:2c] is always one of: ground 2'b00, precharge 2'b01, current source 2'b10. The value 2'b11 never appears.
- R3: A `row_start` sampled high at a clock edge makes `row_clk` high for exactly the following cycle. `row_clk` is never high otherwise.
- R4: Column c belongs to group c mod 3. Group g's precharge length is field `pre_time[4g+3:4g]`. After a row start, each column of group g shows precharge during exactly that many exposure ticks.
- R5: `row_pre_done` is high only when a row has been started and no group is still precharging. While it is high, no column shows precharge. It stays high until the next `row_start`.
- R6: A column shows current source only after its group's precharge has ended. It stays in that state for exactly E exposure ticks, where E is its value in `exp_data[6c+5:6c]` (0 to 63).
- R7: A column with exposure value 0 never shows current source. It goes from precharge, or directly if the group's precharge is zero, to ground for the whole row.
- R8: After its exposure ticks are used up, a column stays at ground until the next `row_start`.
- R9: A group whose precharge length is 0 skips precharge. Its columns enter current source, or ground if E is 0, in the first cycle after the row start.
- R10: A `row_start` in the middle of a row abandons the old row at once. It reloads every counter and timer from the current inputs.
- R11: Counters and timers advance only on clock edges where `exp_tick` is high. With `exp_tick` low and no `row_start`, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| row_start | input | 1 | Latch-enable pulse: load exposures and begin a row |
| exp_tick | input | 1 | Exposure-clock enable, one tick per exposure unit |
| exp_data | input | 6*NUM_COLS | Packed exposure values, column c at [6c+5:6c] |
| pre_time | input | 12 | Precharge ticks per group, group g at [4g+3:4g] |
| col_state | output | 2*NUM_COLS | Packed drive states, column c at [2c+1:2c] |
| row_clk | output | 1 | One-cycle pulse marking a new row |
| row_pre_done | output | 1 | High once every group has finished precharging |

## Verification
The bench goes after the following corner cases:
- Exposure 0 and 63 in the same row. A counter that wraps, or an off-by-one load, would light a zero column for 64 ticks or give the maximum column 62 or 64 ticks.
- Zero and maximum precharge lengths in different groups. A design that applied one group's timer to another would show precharge on the wrong columns. A design that did not skip a zero precharge would add a tick of precharge.
- Sparse exposure ticks. These expose a counter that runs on the system clock instead of the tick.
- A row start in the middle of a row. This shows whether stale counts survive the reload.

Each column's on-time and precharge-time are totalled from the outputs and compared with the programmed values.

// File: rtl/rexp_pkg.sv
package rexp_pkg;

    localparam int NUM_GROUPS = 3;

    typedef enum logic [1:0] {
        DRV_GND = 2'b00,
        DRV_PRE = 2'b01,
        DRV_SRC = 2'b10
    } drive_e;

    function automatic int group_of(input int col);
        return col % NUM_GROUPS;
    endfunction

    function automatic drive_e pick_drive(input logic pre_busy, input logic cnt_live);
        if (pre_busy)
            return DRV_PRE;
        else if (cnt_live)
            return DRV_SRC;
        else
            return DRV_GND;
    endfunction

endpackage

// File: rtl/rexp_group_timer.sv
module rexp_group_timer
    import rexp_pkg::*;
#(
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             tick,
    input  logic [PRE_W-1:0] pre_len,
    output logic             busy
);

    logic [PRE_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (load)
            remain <= pre_len;
        else if (tick && remain != '0)
            remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/rexp_row_ctrl.sv
module rexp_row_ctrl
    import rexp_pkg::*;
#(
    parameter int PRE_W = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        row_start,
    input  logic                        exp_tick,
    input  logic [NUM_GROUPS*PRE_W-1:0] pre_time,
    output logic [NUM_GROUPS-1:0]       grp_busy,
    output logic                        row_clk,
    output logic                        row_pre_done
);

    logic row_open;
    logic clk_pulse;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        rexp_group_timer #(.PRE_W(PRE_W)) u_timer (
            .clk     (clk),
            .rst     (rst),
            .load    (row_start),
            .tick    (exp_tick),
            .pre_len (pre_time[g*PRE_W +: PRE_W]),
            .busy    (grp_busy[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_open  <= 1'b0;
            clk_pulse <= 1'b0;
        end else begin
            clk_pulse <= row_start;
            if (row_start)
                row_open <= 1'b1;
        end
    end

    assign row_clk      = clk_pulse;
    assign row_pre_done = row_open && (grp_busy == '0);

endmodule

// File: rtl/rexp_col_pwm.sv
module rexp_col_pwm
    import rexp_pkg::*;
#(
    parameter int EXP_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             tick,
    input  logic             pre_busy,
    input  logic [EXP_W-1:0] exp_val,
    output drive_e           drive
);

    logic [EXP_W-1:0] left;
    logic             live;

    assign live = (left != '0);

    always_ff @(posedge clk) begin
        if (rst)
            left <= '0;
        else if (load)
            left <= exp_val;
        else if (tick && !pre_busy && live)
            left <= left - 1'b1;
    end

    assign drive = pick_drive(pre_busy, live);

endmodule

// File: rtl/row_exposure_sequencer.sv
module row_exposure_sequencer
    import rexp_pkg::*;
#(
    parameter int NUM_COLS = 12,
    parameter int EXP_W    = 6,
    parameter int PRE_W    = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        row_start,
    input  logic                        exp_tick,
    input  logic [NUM_COLS*EXP_W-1:0]   exp_data,
    input  logic [NUM_GROUPS*PRE_W-1:0] pre_time,
    output logic [2*NUM_COLS-1:0]       col_state,
    output logic                        row_clk,
    output logic                        row_pre_done
);

    logic [NUM_GROUPS-1:0] grp_busy;
    drive_e                drv [NUM_COLS];

    rexp_row_ctrl #(.PRE_W(PRE_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .row_start    (row_start),
        .exp_tick     (exp_tick),
        .pre_time     (pre_time),
        .grp_busy     (grp_busy),
        .row_clk      (row_clk),
        .row_pre_done (row_pre_done)
    );

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        localparam int GRP = group_of(c);
        rexp_col_pwm #(.EXP_W(EXP_W)) u_pwm (
            .clk      (clk),
            .rst      (rst),
            .load     (row_start),
            .tick     (exp_tick),
            .pre_busy (grp_busy[GRP]),
            .exp_val  (exp_data[c*EXP_W +: EXP_W]),
            .drive    (drv[c])
        );
        assign col_state[2*c +: 2] = drv[c];
    end

endmodule

// File: rtl/rexp_chk.sv
module rexp_chk #(
    parameter int NUM_COLS = 12
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  row_start,
    input logic                  exp_tick,
    input logic [2*NUM_COLS-1:0] col_state,
    input logic                  row_clk,
    input logic                  row_pre_done
);

    // R3
    row_clk_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
        row_start |=> row_clk);

    // R3
    row_clk_only_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        row_clk |-> $past(row_start));

    // R5
    pre_done_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (row_pre_done && !row_start) |=> row_pre_done);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!exp_tick && !row_start) |=> $stable(col_state));

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col_chk
        // R2
        legal_code_chk: assert property (@(posedge clk) disable iff (rst)
            col_state[2*c +: 2] != 2'b11);

        // R5
        no_pre_when_done_chk: assert property (@(posedge clk) disable iff (rst)
            row_pre_done |-> (col_state[2*c +: 2] != 2'b01));

        // R8
        ground_stays_chk: assert property (@(posedge clk) disable iff (rst)
            (row_pre_done && col_state[2*c +: 2] == 2'b00 && !row_start)
                |=> col_state[2*c +: 2] == 2'b00);
    end

endmodule

bind row_exposure_sequencer rexp_chk #(.NUM_COLS(NUM_COLS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .row_start    (row_start),
    .exp_tick     (exp_tick),
    .col_state    (col_state),
    .row_clk      (row_clk),
    .row_pre_done (row_pre_done)
);

// File: tb/row_exposure_sequencer_tb.sv
module row_exposure_sequencer_tb;

    localparam int N     = 12;
    localparam int EXP_W = 6;
    localparam int PRE_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic row_start = 1'b0;
    logic exp_tick = 1'b0;
    logic [N*EXP_W-1:0] exp_data = '0;
    logic [3*PRE_W-1:0] pre_time = '0;
    logic [2*N-1:0]     col_state;
    logic               row_clk;
    logic               row_pre_done;

    always #2 clk = ~clk;

    row_exposure_sequencer #(.NUM_COLS(N), .EXP_W(EXP_W), .PRE_W(PRE_W)) u_dut (
        .clk(clk), .rst(rst), .row_start(row_start), .exp_tick(exp_tick),
        .exp_data(exp_data), .pre_time(pre_time), .col_state(col_state),
        .row_clk(row_clk), .row_pre_done(row_pre_done)
    );

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // behavioural model
    int ev  [N];
    int pv  [3];
    int m_cnt [N];
    int m_pre [3];
    bit m_active = 0;
    bit m_rclk = 0;
    int on_ticks [N];
    int pre_ticks [N];

    function automatic int exp_code(input int c);
        if (m_pre[c % 3] > 0) return 1;
        if (m_cnt[c] > 0) return 2;
        return 0;
    endfunction

    task automatic pack_inputs();
        for (int c = 0; c < N; c++) exp_data[c*EXP_W +: EXP_W] = EXP_W'(ev[c]);
        for (int g = 0; g < 3; g++) pre_time[g*PRE_W +: PRE_W] = PRE_W'(pv[g]);
    endtask

    task automatic compare();
        bit pd;
        pd = m_active && m_pre[0] == 0 && m_pre[1] == 0 && m_pre[2] == 0;
        vectors++;
        if (row_clk !== m_rclk) begin
            fails++;
            $display("FAIL R3 row_clk actual=%0b expected=%0b t=%0t", row_clk, m_rclk, $time);
        end
        if (row_pre_done !== pd) begin
            fails++;
            $display("FAIL R5 row_pre_done actual=%0b expected=%0b t=%0t", row_pre_done, pd, $time);
        end
        for (int c = 0; c < N; c++) begin
            int e;
            e = exp_code(c);
            if (col_state[2*c +: 2] === 2'b11) begin
                fails++;
                $display("FAIL R2 col %0d actual=3 expected=%0d", c, e);
            end else if (col_state[2*c +: 2] !== 2'(e)) begin
                fails++;
                if (!m_active)
                    $display("FAIL R1 col %0d actual=%0d expected=%0d", c, col_state[2*c +: 2], e);
                else if (e == 1 || col_state[2*c +: 2] == 2'b01)
                    $display("FAIL R4 col %0d actual=%0d expected=%0d", c, col_state[2*c +: 2], e);
                else if (ev[c] == 0)
                    $display("FAIL R7 col %0d actual=%0d expected=%0d", c, col_state[2*c +: 2], e);
                else if (e == 2)
                    $display("FAIL R6 col %0d actual=%0d expected=%0d", c, col_state[2*c +: 2], e);
                else
                    $display("FAIL R8 col %0d actual=%0d expected=%0d", c, col_state[2*c +: 2], e);
            end
        end
    endtask

    task automatic cyc(input bit rs, input bit et);
        @(negedge clk);
        compare();
        if (!rs && et && !rst) begin
            for (int c = 0; c < N; c++) begin
                if (col_state[2*c +: 2] == 2'b10) on_ticks[c]++;
                if (col_state[2*c +: 2] == 2'b01) pre_ticks[c]++;
            end
        end
        if (rs) begin
            for (int c = 0; c < N; c++) begin on_ticks[c] = 0; pre_ticks[c] = 0; end
        end
        row_start = rs;
        exp_tick  = et;
        @(posedge clk);
        if (rst) begin
            m_active = 0; m_rclk = 0;
            for (int g = 0; g < 3; g++) m_pre[g] = 0;
            for (int c = 0; c < N; c++) m_cnt[c] = 0;
        end else begin
            m_rclk = rs;
            if (rs) begin
                m_active = 1;
                for (int g = 0; g < 3; g++) m_pre[g] = pv[g];
                for (int c = 0; c < N; c++) m_cnt[c] = ev[c];
            end else if (et) begin
                for (int c = 0; c < N; c++)
                    if (m_pre[c % 3] == 0 && m_cnt[c] > 0) m_cnt[c]--;
                for (int g = 0; g < 3; g++)
                    if (m_pre[g] > 0) m_pre[g]--;
            end
        end
    endtask

    // R4 R6 R7 R9: totals observed at the outputs over a finished row
    task automatic check_row();
        for (int c = 0; c < N; c++) begin
            vectors++;
            if (on_ticks[c] != ev[c]) begin
                fails++;
                if (ev[c] == 0)
                    $display("FAIL R7 col %0d on-ticks actual=%0d expected=0", c, on_ticks[c]);
                else
                    $display("FAIL R6 col %0d on-ticks actual=%0d expected=%0d", c, on_ticks[c], ev[c]);
            end
            vectors++;
            if (pre_ticks[c] != pv[c % 3]) begin
                fails++;
                if (pv[c % 3] == 0)
                    $display("FAIL R9 col %0d pre-ticks actual=%0d expected=0", c, pre_ticks[c]);
                else
                    $display("FAIL R4 col %0d pre-ticks actual=%0d expected=%0d", c, pre_ticks[c], pv[c % 3]);
            end
        end
    endtask

    task automatic run_row(input int gap, input int len);
        cyc(1, 0);
        for (int i = 0; i < len; i++) cyc(0, (i % gap) == 0);
    endtask

    initial begin
        for (int c = 0; c < N; c++) ev[c] = c * 5 + 1;
        pv[0] = 3; pv[1] = 2; pv[2] = 1;
        pack_inputs();
        // R1: reset with stimulus present
        rst = 1;
        for (int i = 0; i < 5; i++) cyc(i % 2, 1);
        rst = 0;
        // R1 / R11: ticks before any row start do nothing
        for (int i = 0; i < 10; i++) cyc(0, 1);

        // row A: mixed values incl. 0 and 63, ticks every cycle
        ev = '{0, 63, 1, 2, 10, 0, 63, 33, 5, 17, 0, 1};
        pv = '{3, 2, 1};
        pack_inputs();
        run_row(1, 80);
        check_row();

        // row B: sparse ticks (R11), zero precharge in groups 0 and 2 (R9)
        ev = '{7, 0, 12, 1, 63, 4, 0, 9, 2, 30, 3, 0};
        pv = '{0, 5, 0};
        pack_inputs();
        run_row(3, 3 * 75);
        check_row();

        // R10: abort mid-row, then a full row from new values
        ev = '{40, 40, 40, 40, 40, 40, 40, 40, 40, 40, 40, 40};
        pv = '{2, 2, 2};
        pack_inputs();
        run_row(1, 12);
        ev = '{1, 2, 3, 0, 5, 6, 0, 8, 9, 10, 11, 63};
        pv = '{15, 0, 4};
        pack_inputs();
        run_row(2, 2 * 85);
        check_row();

        // row D: all max
        ev = '{63, 63, 63, 63, 63, 63, 63, 63, 63, 63, 63, 63};
        pv = '{15, 15, 15};
        pack_inputs();
        run_row(1, 85);
        check_row();

        // R8: long idle after completion, ground persists
        for (int i = 0; i < 20; i++) cyc(0, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule